// File: doc/BRIEF.md
# Fixed-Point Status Flag Unit

This block keeps the fixed-point status flags of a processor core: carry, 32-bit carry, overflow, 32-bit overflow and a sticky summary-overflow bit. It stores them in three 2-bit registers. The first register holds summary overflow in its low bit. The second holds the carry pair. The third holds the overflow pair. Execution units send per-instruction updates through a masked port for each pair. A move-to write replaces the whole flag set at once, and it is the only way to clear summary overflow.

On the read side, the block gives the summary bit to compare and record-form instructions, which place it in the last position of their 4-bit condition field. It also gives a packed 4-bit copy of the overflow and carry pairs for a move-flags-to-condition operation, and all three registers in one 6-bit word. Readers may take the summary bit before older instructions have finished. When the reading instruction completes, it presents the value it saw. If that value differs from the committed value, the block raises a flush request.

Top module: `fxs_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears every flag, so `flags_all`, `crf_pack` and `so_rd` read 0 after reset.
- R2: An execution update writes only the carry-pair bits selected by `eu_ca_we`. Bit 1 is carry and bit 0 is 32-bit carry. Unselected bits keep their value.
- R3: An execution update writes only the overflow-pair bits selected by `eu_ov_we`. Bit 1 is overflow and bit 0 is 32-bit overflow. Writing overflow bit 1 as 1 also sets summary overflow.
- R4: Summary overflow is sticky. An execution update that writes overflow as 0 leaves it at 1.
- R5: A move-to write (`mt_valid`) loads all five flags from `mt_so`, `mt_ca` and `mt_ov`, including clearing summary overflow.
- R6: When a move-to write and execution updates fall in the same cycle, the move-to values win for every flag.
- R7: `cmp_field` equals {`cmp_bits`[2], `cmp_bits`[1], `cmp_bits`[0], summary overflow}, so summary overflow sits at bit 0.
- R8: `crf_pack` equals {overflow, 32-bit overflow, carry, 32-bit carry} from bit 3 down to bit 0. Reading it changes no flag.
- R9: Reads in a cycle show the stored values from before that cycle's writes. No write-to-read bypass is provided.
- R10: `flush_req` is 1 exactly when `cmpl_valid` is 1 and `cmpl_so_seen` differs from the stored summary overflow.
- R11: `flags_all` is {1'b0, summary overflow, carry, 32-bit carry, overflow, 32-bit overflow} from bit 5 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eu_ca_we | input | 2 | Carry-pair write mask from an execution unit |
| eu_ca_val | input | 2 | Carry-pair values {carry, carry32} |
| eu_ov_we | input | 2 | Overflow-pair write mask from an execution unit |
| eu_ov_val | input | 2 | Overflow-pair values {overflow, overflow32} |
| mt_valid | input | 1 | Move-to write of the whole flag set |
| mt_so | input | 1 | Summary overflow value for the move-to write |
| mt_ca | input | 2 | Carry pair for the move-to write |
| mt_ov | input | 2 | Overflow pair for the move-to write |
| cmp_bits | input | 3 | Less, greater and equal bits of a compare result |
| cmpl_valid | input | 1 | A reader of summary overflow is completing |
| cmpl_so_seen | input | 1 | Summary overflow value that reader used |
| so_rd | output | 1 | Stored summary overflow |
| cmp_field | output | 4 | Compare condition field with summary overflow at bit 0 |
| crf_pack | output | 4 | Packed overflow and carry pairs |
| flags_all | output | 6 | All three registers in one word |
| flush_req | output | 1 | Flush request on a summary-overflow mismatch |

## Verification
A move-to write and execution-unit updates can arrive in the same cycle. The case that matters is an overflow-setting update that would set the sticky bit while the move-to write clears it. The bench provokes this both in directed steps and with a pseudo-random pattern that drives both ports at once. Its scoreboard model, built from the requirements, gives the move-to values priority for every flag. The next cycle's outputs are judged against that model. A completion check in the same cycle as a write is judged against the value stored before the write.

// File: rtl/fxs_flag_pkg.sv
package fxs_flag_pkg;

    localparam int PAIR_W   = 2;
    localparam int NUM_REGS = 3;
    localparam int CRF_W    = 2 * PAIR_W;
    localparam int ALL_W    = NUM_REGS * PAIR_W;

    typedef enum int {
        REG_SUM = 0,
        REG_CAR = 1,
        REG_OVF = 2
    } flag_reg_e;

    typedef struct packed {
        logic [PAIR_W-1:0] mask;
        logic [PAIR_W-1:0] data;
    } pair_wr_t;

    function automatic logic [PAIR_W-1:0] merge_pair(
        input logic [PAIR_W-1:0] old_v,
        input pair_wr_t          wr
    );
        return (old_v & ~wr.mask) | (wr.data & wr.mask);
    endfunction

    function automatic logic [CRF_W-1:0] pack_crf(
        input logic [PAIR_W-1:0] ovf,
        input logic [PAIR_W-1:0] car
    );
        return {ovf, car};
    endfunction

endpackage

// File: rtl/fxs_flag_pair.sv
module fxs_flag_pair
    import fxs_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pair_wr_t          wr,
    output logic [PAIR_W-1:0] q
);

    logic [PAIR_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= merge_pair(q_r, wr);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/fxs_wr_arbiter.sv
module fxs_wr_arbiter
    import fxs_flag_pkg::*;
(
    input  logic [PAIR_W-1:0] eu_ca_we,
    input  logic [PAIR_W-1:0] eu_ca_val,
    input  logic [PAIR_W-1:0] eu_ov_we,
    input  logic [PAIR_W-1:0] eu_ov_val,
    input  logic              mt_valid,
    input  logic              mt_so,
    input  logic [PAIR_W-1:0] mt_ca,
    input  logic [PAIR_W-1:0] mt_ov,
    output pair_wr_t          wr [NUM_REGS]
);

    logic ov_set;

    // The main overflow bit of the pair is its upper bit.
    assign ov_set = eu_ov_we[PAIR_W-1] & eu_ov_val[PAIR_W-1];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            wr[i] = '0;
        end
        if (mt_valid) begin
            wr[REG_SUM].mask = PAIR_W'(1);
            wr[REG_SUM].data = PAIR_W'(mt_so);
            wr[REG_CAR].mask = '1;
            wr[REG_CAR].data = mt_ca;
            wr[REG_OVF].mask = '1;
            wr[REG_OVF].data = mt_ov;
        end else begin
            // The sticky bit is only ever set here, never cleared.
            wr[REG_SUM].mask = PAIR_W'(ov_set);
            wr[REG_SUM].data = PAIR_W'(1);
            wr[REG_CAR].mask = eu_ca_we;
            wr[REG_CAR].data = eu_ca_val;
            wr[REG_OVF].mask = eu_ov_we;
            wr[REG_OVF].data = eu_ov_val;
        end
    end

endmodule

// File: rtl/fxs_so_check.sv
module fxs_so_check (
    input  logic cmpl_valid,
    input  logic cmpl_so_seen,
    input  logic so_committed,
    output logic flush_req
);

    assign flush_req = cmpl_valid & (cmpl_so_seen ^ so_committed);

endmodule

// File: rtl/fxs_flag_unit.sv
module fxs_flag_unit
    import fxs_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] eu_ca_we,
    input  logic [1:0] eu_ca_val,
    input  logic [1:0] eu_ov_we,
    input  logic [1:0] eu_ov_val,
    input  logic       mt_valid,
    input  logic       mt_so,
    input  logic [1:0] mt_ca,
    input  logic [1:0] mt_ov,
    input  logic [2:0] cmp_bits,
    input  logic       cmpl_valid,
    input  logic       cmpl_so_seen,
    output logic       so_rd,
    output logic [3:0] cmp_field,
    output logic [3:0] crf_pack,
    output logic [5:0] flags_all,
    output logic       flush_req
);

    pair_wr_t          wr [NUM_REGS];
    logic [PAIR_W-1:0] q  [NUM_REGS];

    fxs_wr_arbiter u_arb (
        .eu_ca_we  (eu_ca_we),
        .eu_ca_val (eu_ca_val),
        .eu_ov_we  (eu_ov_we),
        .eu_ov_val (eu_ov_val),
        .mt_valid  (mt_valid),
        .mt_so     (mt_so),
        .mt_ca     (mt_ca),
        .mt_ov     (mt_ov),
        .wr        (wr)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            fxs_flag_pair u_pair (
                .clk (clk),
                .rst (rst),
                .wr  (wr[g]),
                .q   (q[g])
            );
        end
    endgenerate

    assign so_rd     = q[REG_SUM][0];
    assign cmp_field = {cmp_bits, so_rd};
    assign crf_pack  = pack_crf(q[REG_OVF], q[REG_CAR]);
    assign flags_all = {q[REG_SUM], q[REG_CAR], q[REG_OVF]};

    fxs_so_check u_chk_so (
        .cmpl_valid   (cmpl_valid),
        .cmpl_so_seen (cmpl_so_seen),
        .so_committed (so_rd),
        .flush_req    (flush_req)
    );

endmodule

// File: rtl/fxs_flag_unit_chk.sv
module fxs_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] eu_ca_we,
    input logic [1:0] eu_ov_we,
    input logic [1:0] eu_ov_val,
    input logic       mt_valid,
    input logic       mt_so,
    input logic       cmpl_valid,
    input logic       so_rd,
    input logic [3:0] crf_pack,
    input logic       flush_req
);

    // R4: sticky unless a move-to write arrives
    a_r4_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (so_rd && !mt_valid) |=> so_rd);

    // R3: writing overflow as 1 sets the summary bit
    a_r3_ov_sets_so: assert property (@(posedge clk) disable iff (rst)
        (!mt_valid && eu_ov_we[1] && eu_ov_val[1]) |=> so_rd);

    // R5 and R6: a move-to write decides the summary bit
    a_r5_mt_sets_so: assert property (@(posedge clk) disable iff (rst)
        mt_valid |=> (so_rd == $past(mt_so)));

    // R10: no flush without a completing reader
    a_r10_flush_needs_cmpl: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> cmpl_valid);

    // R8: with no writes, the packed pairs hold
    a_r8_pack_stable: assert property (@(posedge clk) disable iff (rst)
        (!mt_valid && eu_ca_we == 2'b00 && eu_ov_we == 2'b00) |=> $stable(crf_pack));

endmodule

bind fxs_flag_unit fxs_flag_unit_chk u_flag_chk (
    .clk        (clk),
    .rst        (rst),
    .eu_ca_we   (eu_ca_we),
    .eu_ov_we   (eu_ov_we),
    .eu_ov_val  (eu_ov_val),
    .mt_valid   (mt_valid),
    .mt_so      (mt_so),
    .cmpl_valid (cmpl_valid),
    .so_rd      (so_rd),
    .crf_pack   (crf_pack),
    .flush_req  (flush_req)
);

// File: tb/fxs_flag_unit_bench.sv
module fxs_flag_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] eu_ca_we = '0, eu_ca_val = '0, eu_ov_we = '0, eu_ov_val = '0;
    logic       mt_valid = 1'b0, mt_so = 1'b0;
    logic [1:0] mt_ca = '0, mt_ov = '0;
    logic [2:0] cmp_bits = '0;
    logic       cmpl_valid = 1'b0, cmpl_so_seen = 1'b0;
    logic       so_rd, flush_req;
    logic [3:0] cmp_field, crf_pack;
    logic [5:0] flags_all;

    fxs_flag_unit u_fxs_flag_unit (.*);

    always #10 clk = ~clk;

    typedef struct {
        string      req;
        logic [5:0] all;
        logic [3:0] crf;
        logic [3:0] cmpf;
        logic       so;
        logic       flush;
    } exp_t;

    exp_t q_exp[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Bench model of the stored flags
    logic       m_so = 0;
    logic [1:0] m_ca = '0, m_ov = '0;

    task automatic step(
        input string      req,
        input logic       mv, input logic ms, input logic [1:0] mc, input logic [1:0] mo,
        input logic [1:0] cw, input logic [1:0] cv,
        input logic [1:0] ow, input logic [1:0] ovv,
        input logic       cpv, input logic seen, input logic [2:0] cb
    );
        exp_t e;
        @(negedge clk);
        mt_valid = mv; mt_so = ms; mt_ca = mc; mt_ov = mo;
        eu_ca_we = cw; eu_ca_val = cv; eu_ov_we = ow; eu_ov_val = ovv;
        cmpl_valid = cpv; cmpl_so_seen = seen; cmp_bits = cb;
        #1;
        // R9: outputs this cycle show state before this cycle's writes
        e.req   = req;
        e.all   = {1'b0, m_so, m_ca, m_ov};
        e.crf   = {m_ov, m_ca};
        e.cmpf  = {cb, m_so};
        e.so    = m_so;
        e.flush = cpv && (seen != m_so);
        q_exp.push_back(e);
        if (mv) begin
            m_so = ms; m_ca = mc; m_ov = mo;
        end else begin
            m_ca = (m_ca & ~cw) | (cv & cw);
            m_ov = (m_ov & ~ow) | (ovv & ow);
            if (ow[1] && ovv[1]) m_so = 1'b1;
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        #2;
        if (q_exp.size() > 0) begin
            e = q_exp.pop_front();
            n_checks++;
            if (flags_all !== e.all || crf_pack !== e.crf || cmp_field !== e.cmpf ||
                so_rd !== e.so || flush_req !== e.flush) begin
                n_fail++;
                $display("FAIL %s: all=%b crf=%b cmp=%b so=%b flush=%b expected all=%b crf=%b cmp=%b so=%b flush=%b",
                         e.req, flags_all, crf_pack, cmp_field, so_rd, flush_req,
                         e.all, e.crf, e.cmpf, e.so, e.flush);
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        // reset with a move-to write pending: reset wins (R1)
        mt_valid = 1'b1; mt_so = 1'b1; mt_ca = 2'b11; mt_ov = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mt_valid = 1'b0;
        // R1: reset state
        step("R1", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 0,0,3'b000);
        // R2: write carry only
        step("R2", 0,0,2'b00,2'b00, 2'b10,2'b11, 2'b00,2'b00, 0,0,3'b000);
        // R2: write carry32 only, carry kept
        step("R2", 0,0,2'b00,2'b00, 2'b01,2'b01, 2'b00,2'b00, 0,0,3'b100);
        // R3: overflow32 only, summary untouched
        step("R3", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b01,2'b01, 0,0,3'b010);
        // R3: overflow set, summary set
        step("R3", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b10,2'b10, 0,0,3'b001);
        // R4: overflow pair cleared, summary sticks
        step("R4", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b11,2'b00, 1,0,3'b000);
        // R10: mismatch raises flush
        step("R10", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 1,0,3'b100);
        // R10: match, no flush
        step("R10", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 1,1,3'b010);
        // R10: mismatch without completion, no flush; R8 read leaves flags
        step("R8", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 0,0,3'b110);
        // R5: move-to write clears summary
        step("R5", 1,0,2'b01,2'b10, 2'b00,2'b00, 2'b00,2'b00, 1,0,3'b000);
        // R9: completion in same cycle as a write uses old value
        step("R9", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b10,2'b10, 1,1,3'b001);
        // R6: move-to beats overflow-setting and carry updates
        step("R6", 1,0,2'b00,2'b00, 2'b11,2'b10, 2'b11,2'b11, 1,1,3'b000);
        // R7/R11: observe cleared result
        step("R7", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 0,0,3'b111);
        // R5: move-to loads all ones
        step("R5", 1,1,2'b11,2'b11, 2'b00,2'b00, 2'b00,2'b00, 0,0,3'b000);
        step("R11", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 1,0,3'b011);
        // R6: mixed pseudo-random traffic on both ports
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R6", lfsr[0] & lfsr[7], lfsr[1], lfsr[3:2], lfsr[5:4],
                 lfsr[7:6], lfsr[9:8], lfsr[11:10], lfsr[13:12],
                 lfsr[14], lfsr[15], lfsr[2:0]);
        end
        step("R9", 0,0,2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00, 0,0,3'b000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule